// File: doc/BRIEF.md
# Cascaded Biquad Sine Shaper

This block turns a one-bit square wave into a stream of signed fixed-point samples that approximate a sine. Every clock the incoming bit is turned into a level of plus or minus one, or zero while the enable is low. That level passes through two second-order recursive sections in series. Both sections have the numerator (1, 2, 1) but different feedback weights. Between the sections the signal is scaled by one eighth and held in a register for one sample. The output of the second section is registered once more before it leaves the block.

The coefficients are set for a square wave that completes one period every eight clocks. For that input the low-pass sections remove the harmonics and keep the fundamental. The block runs on the same clock as the square-wave source. It contains no divider and no analog stage. Samples carry `FRAC` fractional bits in a `W`-bit two's-complement word. Every sum is clamped to that word instead of being allowed to wrap.

Top module: `sine_shaper_filter`

## Requirements
- R1: With `en_i` high, `sq_i`=1 maps to +1.0 (2^FRAC) and `sq_i`=0 maps to -1.0. With `en_i` low the mapped level is 0.
- R2: Each section with input x and state registers s0, s1 computes y = s1 + x, s0' = x + f0*y and s1' = s0 + 2*x + f1*y. Both registers update on the same edge.
- R3: Each feedback weight is rounded to the nearest multiple of 2^-FRAC. Section one uses f0 = -0.75 and f1 = 0.5625. Section two uses f0 = -0.3438 and f1 = 1.0.
- R4: The output of section one is multiplied by 1/8, rounded half up, and registered. The registered value is the input to section two.
- R5: `sample_o` is the output of section two delayed by one register. From an all-zero state, a single enabled +1 sample gives 0, then 2048, then 11392 on the following edges (FRAC=14).
- R6: A synchronous active-high `rst` clears every state and delay register. `sample_o` reads 0 after the reset edge.
- R7: Every sum saturates to the W-bit signed range. With W=16, a held +1 input settles at 32767 and a held -1 input settles at -32768.
- R8: While `en_i` is low and the filter is at rest, `sample_o` stays exactly 0 whatever `sq_i` does.
- R9: For a square wave of period 8 clocks held for 64 periods, and for the other patterns, every output sample is within 32 LSB of an exact-arithmetic model that uses the rounded coefficients.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Input enable; when low the input level is zero |
| sq_i | input | 1 | One-bit square-wave input |
| sample_o | output | W | Signed output sample with FRAC fractional bits |

## Verification
The main stimulus is the period-8 square wave. It shows whether the cascade produces the intended sine and whether both sets of feedback weights are correct. Held high and held low inputs check the DC gain of each section, which depends on the coefficients. A period-16 wave and an alternating input check the response away from the design frequency. The alternating input also checks the numerator zero at half the sample rate. Single-sample pulses of each polarity confirm the mapping, the pipeline depth and the exact first output values. A narrow 16-bit instance driven to its limits checks that sums clamp rather than wrap.

// File: rtl/sine_shaper_pkg.sv
package sine_shaper_pkg;

    localparam int ACC_W = 48;
    localparam int CW    = 16;

    typedef logic signed [ACC_W-1:0] acc_t;

    typedef struct packed {
        logic signed [CW-1:0] fb0;
        logic signed [CW-1:0] fb1;
    } coef_pair_t;

    typedef enum logic [1:0] {
        LVL_ZERO = 2'd0,
        LVL_POS  = 2'd1,
        LVL_NEG  = 2'd2
    } level_e;

    // Nearest representable coefficient with frac fractional bits.
    function automatic logic signed [CW-1:0] q_coef(input real c, input int frac);
        return CW'($rtoi($floor(c * (2.0 ** frac) + 0.5)));
    endfunction

    // Feedback weights per section index.
    function automatic coef_pair_t sect_fb(input int idx, input int frac);
        coef_pair_t r;
        if (idx == 0) begin
            r.fb0 = q_coef(-0.75, frac);
            r.fb1 = q_coef(0.5625, frac);
        end else begin
            r.fb0 = q_coef(-0.3438, frac);
            r.fb1 = q_coef(1.0, frac);
        end
        return r;
    endfunction

    // Clamp a wide value into the w-bit signed range.
    function automatic acc_t sat_w(input acc_t v, input int w);
        acc_t hi;
        acc_t lo;
        hi = (acc_t'(1) <<< (w - 1)) - acc_t'(1);
        lo = -(acc_t'(1) <<< (w - 1));
        if (v > hi) return hi;
        if (v < lo) return lo;
        return v;
    endfunction

    // Fixed-point product, rounded half up.
    function automatic acc_t mul_rnd(input acc_t a, input acc_t c, input int frac);
        acc_t p;
        p = a * c;
        return (p + (acc_t'(1) <<< (frac - 1))) >>> frac;
    endfunction

endpackage

// File: rtl/sine_level_map.sv
module sine_level_map
    import sine_shaper_pkg::*;
#(
    parameter int W    = 24,
    parameter int FRAC = 14
) (
    input  logic                en_i,
    input  logic                sq_i,
    output logic signed [W-1:0] level_o
);

    localparam logic signed [W-1:0] ONE = W'(1) <<< FRAC;

    level_e sel;

    always_comb begin
        if (!en_i)     sel = LVL_ZERO;
        else if (sq_i) sel = LVL_POS;
        else           sel = LVL_NEG;
    end

    always_comb begin
        unique case (sel)
            LVL_POS: level_o = ONE;
            LVL_NEG: level_o = -ONE;
            default: level_o = '0;
        endcase
    end

endmodule

// File: rtl/sine_biquad_sect.sv
module sine_biquad_sect
    import sine_shaper_pkg::*;
#(
    parameter int         W    = 24,
    parameter int         FRAC = 14,
    parameter coef_pair_t FB   = '0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic signed [W-1:0] x_i,
    output logic signed [W-1:0] y_o
);

    logic signed [W-1:0] s0_q;
    logic signed [W-1:0] s1_q;
    acc_t x_w, y_w, s0_n, s1_n;

    always_comb begin
        x_w  = acc_t'(x_i);
        y_w  = sat_w(acc_t'(s1_q) + x_w, W);
        s0_n = sat_w(x_w + mul_rnd(y_w, acc_t'(FB.fb0), FRAC), W);
        s1_n = sat_w(acc_t'(s0_q) + (x_w <<< 1)
                     + mul_rnd(y_w, acc_t'(FB.fb1), FRAC), W);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s0_q <= '0;
            s1_q <= '0;
        end else begin
            s0_q <= W'(s0_n);
            s1_q <= W'(s1_n);
        end
    end

    assign y_o = W'(y_w);

endmodule

// File: rtl/sine_stage_scale.sv
module sine_stage_scale
    import sine_shaper_pkg::*;
#(
    parameter int W     = 24,
    parameter int SHIFT = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic signed [W-1:0] d_i,
    output logic signed [W-1:0] q_o
);

    localparam acc_t RND = acc_t'(1) <<< (SHIFT - 1);

    acc_t scaled;

    always_comb scaled = (acc_t'(d_i) + RND) >>> SHIFT;

    always_ff @(posedge clk) begin
        if (rst) q_o <= '0;
        else     q_o <= W'(scaled);
    end

endmodule

// File: rtl/sine_shaper_filter.sv
module sine_shaper_filter
    import sine_shaper_pkg::*;
#(
    parameter int W           = 24,
    parameter int FRAC        = 14,
    parameter int STAGE_SHIFT = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en_i,
    input  logic                sq_i,
    output logic signed [W-1:0] sample_o
);

    localparam int NSECT = 2;

    logic signed [W-1:0] level;
    logic signed [W-1:0] stage_q;
    logic signed [W-1:0] sample_q;
    logic signed [W-1:0] sect_in  [NSECT];
    logic signed [W-1:0] sect_out [NSECT];

    sine_level_map #(.W(W), .FRAC(FRAC)) u_map (
        .en_i    (en_i),
        .sq_i    (sq_i),
        .level_o (level)
    );

    assign sect_in[0] = level;
    assign sect_in[1] = stage_q;

    for (genvar i = 0; i < NSECT; i++) begin : gen_sect
        sine_biquad_sect #(
            .W    (W),
            .FRAC (FRAC),
            .FB   (sect_fb(i, FRAC))
        ) u_sect (
            .clk (clk),
            .rst (rst),
            .x_i (sect_in[i]),
            .y_o (sect_out[i])
        );
    end

    sine_stage_scale #(.W(W), .SHIFT(STAGE_SHIFT)) u_stage (
        .clk (clk),
        .rst (rst),
        .d_i (sect_out[0]),
        .q_o (stage_q)
    );

    always_ff @(posedge clk) begin
        if (rst) sample_q <= '0;
        else     sample_q <= sect_out[NSECT-1];
    end

    assign sample_o = sample_q;

endmodule

// File: rtl/sine_shaper_chk.sv
module sine_shaper_chk #(
    parameter int W = 24
) (
    input logic                clk,
    input logic                rst,
    input logic                en_i,
    input logic signed [W-1:0] level_i,
    input logic signed [W-1:0] y1_i,
    input logic signed [W-1:0] y2_i,
    input logic signed [W-1:0] stage_i,
    input logic signed [W-1:0] out_i,
    input logic signed [W-1:0] sa_s0_i,
    input logic signed [W-1:0] sa_s1_i
);

    // R6: all registers read zero after a reset edge
    p_reset_clear_r6: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (out_i == '0 && stage_i == '0 && sa_s0_i == '0 && sa_s1_i == '0));

    // R5: output is the second section delayed by one clock
    p_out_pipe_r5: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (out_i == $past(y2_i)));

    // R4: scaled interstage value never turns a non-negative sample negative
    p_stage_sign_r4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(y1_i[W-1])) |-> !stage_i[W-1]);

    // R7: sums of like-signed terms never wrap to the other sign
    p_no_wrap_pos_r7: assert property (@(posedge clk) disable iff (rst)
        (!sa_s1_i[W-1] && !level_i[W-1]) |-> !y1_i[W-1]);

    p_no_wrap_neg_r7: assert property (@(posedge clk) disable iff (rst)
        (sa_s1_i[W-1] && level_i[W-1]) |-> y1_i[W-1]);

    // R8: a resting first section stays at rest while disabled
    p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!en_i && sa_s0_i == '0 && sa_s1_i == '0)
        |=> (en_i || (sa_s0_i == '0 && sa_s1_i == '0)));

endmodule

bind sine_shaper_filter sine_shaper_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .en_i    (en_i),
    .level_i (level),
    .y1_i    (sect_out[0]),
    .y2_i    (sect_out[1]),
    .stage_i (stage_q),
    .out_i   (sample_q),
    .sa_s0_i (gen_sect[0].u_sect.s0_q),
    .sa_s1_i (gen_sect[0].u_sect.s1_q)
);

// File: tb/sine_shaper_filter_tb.sv
`timescale 1ns/1ps
module sine_shaper_filter_tb_top;

    localparam int    W_MAIN = 24;
    localparam int    W_SAT  = 16;
    localparam int    FRAC   = 14;
    localparam real   SCALE  = 16384.0;
    localparam real   TOL    = 32.0;
    localparam int    NROW   = 6;

    // Stimulus table: enable, half period (0 = constant), constant bit, length
    // row 0: period-8 square wave, 64 periods (R9)
    // row 1: held high, DC gain through both sections (R3)
    // row 2: held low, negative DC gain (R3)
    // row 3: period-16 square wave (R2)
    // row 4: alternating input, numerator zero (R2)
    // row 5: disabled with toggling bit, decay to rest (R8)
    localparam int T_EN   [NROW] = '{1, 1, 1, 1, 1, 0};
    localparam int T_HALF [NROW] = '{4, 0, 0, 8, 1, 2};
    localparam int T_BIT  [NROW] = '{0, 1, 0, 0, 0, 0};
    localparam int T_LEN  [NROW] = '{512, 100, 100, 256, 64, 100};
    localparam int T_REQ  [NROW] = '{9, 3, 3, 2, 2, 8};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en  = 1'b0;
    logic sq  = 1'b0;
    logic signed [W_MAIN-1:0] out_w;
    logic signed [W_SAT-1:0]  out_s;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    sine_shaper_filter #(.W(W_MAIN), .FRAC(FRAC)) dut_i (
        .clk (clk), .rst (rst), .en_i (en), .sq_i (sq), .sample_o (out_w)
    );

    sine_shaper_filter #(.W(W_SAT), .FRAC(FRAC)) dut_sat_i (
        .clk (clk), .rst (rst), .en_i (en), .sq_i (sq), .sample_o (out_s)
    );

    // Exact-arithmetic reference with rounded coefficients
    function automatic real qc(input real c);
        return $floor(c * SCALE + 0.5) / SCALE;
    endfunction

    function automatic real clampm(input real v);
        real hi, lo;
        hi = (2.0 ** (W_MAIN - 1) - 1.0) / SCALE;
        lo = -(2.0 ** (W_MAIN - 1)) / SCALE;
        if (v > hi) return hi;
        if (v < lo) return lo;
        return v;
    endfunction

    real ma0 = 0.0, ma1 = 0.0, mb0 = 0.0, mb1 = 0.0, mg = 0.0, mout = 0.0;

    always @(posedge clk) begin
        real x, y1, y2, na0, na1, nb0, nb1;
        if (rst) begin
            ma0 = 0.0; ma1 = 0.0; mb0 = 0.0; mb1 = 0.0; mg = 0.0; mout = 0.0;
        end else begin
            x   = en ? (sq ? 1.0 : -1.0) : 0.0;
            y1  = clampm(ma1 + x);
            na0 = clampm(x + qc(-0.75) * y1);
            na1 = clampm(ma0 + 2.0 * x + qc(0.5625) * y1);
            y2  = clampm(mb1 + mg);
            nb0 = clampm(mg + qc(-0.3438) * y2);
            nb1 = clampm(mb0 + 2.0 * mg + qc(1.0) * y2);
            ma0 = na0; ma1 = na1; mb0 = nb0; mb1 = nb1;
            mout = y2;
            mg   = y1 / 8.0;
        end
    end

    task automatic chk_int(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_model(input string req);
        real diff;
        checks++;
        diff = real'(out_w) / SCALE - mout;
        if (diff < 0.0) diff = -diff;
        if (diff * SCALE > TOL) begin
            errors++;
            $display("FAIL %s: actual %f expected %f", req, real'(out_w) / SCALE, mout);
        end
    endtask

    task automatic step(input logic e, input logic b);
        en = e;
        sq = b;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        en  = 1'b0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin : watchdog
        #(100000 * 8);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R6: reset state
        chk_int("R6 reset main", out_w, 0);
        chk_int("R6 reset narrow", out_s, 0);
        rst = 1'b0;

        // R5 / R1: positive single-sample pulse
        step(1'b1, 1'b1);
        chk_int("R5 pulse edge1", out_w, 0);
        step(1'b0, 1'b0);
        chk_int("R5 pulse edge2", out_w, 2048);
        step(1'b0, 1'b0);
        chk_int("R5 pulse edge3", out_w, 11392);
        step(1'b0, 1'b0);
        chk_model("R3 pulse edge4");

        // R6: mid-run reset clears everything; R8: disabled bit is ignored
        do_reset();
        chk_int("R6 midrun reset", out_w, 0);
        for (int k = 0; k < 20; k++) begin
            step(1'b0, k[0]);
            chk_int("R8 idle with toggling bit", out_w, 0);
        end

        // R1: negative pulse maps to -1.0
        step(1'b1, 1'b0);
        step(1'b0, 1'b1);
        chk_int("R1 negative pulse", out_w, -2048);
        do_reset();

        // Table walk against the reference model
        for (int r = 0; r < NROW; r++) begin
            for (int k = 0; k < T_LEN[r]; k++) begin
                logic b;
                if (T_HALF[r] == 0) b = T_BIT[r][0];
                else                b = ((k / T_HALF[r]) % 2) == 0;
                step(T_EN[r][0], b);
                chk_model($sformatf("R%0d row %0d sample %0d", T_REQ[r], r, k));
            end
        end

        // R7: narrow instance saturates instead of wrapping
        do_reset();
        for (int k = 0; k < 300; k++) step(1'b1, 1'b1);
        chk_int("R7 positive clamp", out_s, 32767);
        chk_model("R9 held high wide");
        for (int k = 0; k < 300; k++) step(1'b1, 1'b0);
        chk_int("R7 negative clamp", out_s, -32768);
        chk_model("R9 held low wide");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule